// File: doc/BRIEF.md
# Audio Transmit Sample FIFO with Width Normalisation and Packing

This block is the outbound sample path of a serial audio codec link. Each word written from the bus side is turned into one or two 20-bit samples. A narrower sample is aligned to the top of the 20-bit field by a left shift that depends on its width. In compact mode one 32-bit word carries two 16-bit halves. The samples are held in a circular FIFO of parameter depth.

The codec side takes samples as stereo pairs through a valid/ready handshake. The older sample of a pair is the left channel and the next one is the right channel. A drain burst starts only when the channel is on, at least one audio slot is on and the FIFO is at least half full. Once started, the burst goes on for as long as the codec keeps taking a pair every cycle.

Four registered status flags report the fill state: empty, half-empty, full and underrun. They follow update rules tied to push and drain events. They are not decoded from the fill level.

Top module: `aud_tx_fifo`

## Requirements
- R1: `size_sel` gives the sample width: 0 is 16 bits, 1 is 18 bits, 2 is 20 bits, 3 is 12 bits. In normal mode a word is shifted left by 4, 2, 0 or 8 bits for those codes, and bits [19:0] of the result are stored.
- R2: In compact mode a word gives two samples. Bits [15:0] are stored first and bits [31:16] second. Each half is shifted left by 4 for code 0 or by 8 for code 3, and the low 20 bits are kept.
- R3: `compact_req` is ignored when `size_sel` is 1 or 2. The word is then stored as a single normal-mode sample.
- R4: A normal-mode write is taken only while the level is below DEPTH. A compact write is taken only while level+2 is strictly below DEPTH. Any other write is dropped and changes neither the contents nor the flags.
- R5: After reset, `flag_empty` and `flag_half` are 1, `flag_full` and `flag_underrun` are 0, and `pair_valid` is 0.
- R6: A taken write clears `flag_empty` and `flag_underrun`. It clears `flag_half` if the new level is at least DEPTH/2. It sets `flag_full` if the new level is at least DEPTH.
- R7: A new burst starts, and `pair_valid` rises, only when all of these hold: `chan_en` is 1, `slot_en` is nonzero (bit 0 is slot 3, bit 1 is slot 4), and the level is at least DEPTH/2. `left_smp` carries the older sample and `right_smp` the one after it.
- R8: After a pair is taken, `pair_valid` stays 1 in the next cycle while at least two samples remain, even below DEPTH/2. A cycle that takes no pair ends the burst.
- R9: A taken pair clears `flag_full`. It sets `flag_half` if the level left over is at most DEPTH/2. It sets `flag_empty` and `flag_underrun` if the level left over is zero.
- R10: When a write and a pair drain happen in the same cycle, the level changes by the net amount. The write is judged on the level before the drain. The flags apply the push rules first and then the drain rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one bus word |
| wr_data | input | 32 | Bus word |
| chan_en | input | 1 | Transmit channel enable |
| size_sel | input | 2 | Sample width code |
| compact_req | input | 1 | Request two 16-bit samples per word |
| slot_en | input | 2 | Audio slot enables (bit 0 slot 3, bit 1 slot 4) |
| pair_ready | input | 1 | Codec accepts a pair this cycle |
| pair_valid | output | 1 | A stereo pair is offered |
| left_smp | output | 20 | Left (older) sample |
| right_smp | output | 20 | Right (newer) sample |
| flag_empty | output | 1 | Empty flag |
| flag_half | output | 1 | Half-empty flag |
| flag_full | output | 1 | Full flag |
| flag_underrun | output | 1 | Underrun flag |

## Verification
A fill level that drifts from the real contents shows at the ports within a few cycles. `pair_valid` then rises one write too early or too late against the DEPTH/2 threshold, or `flag_empty` rises while a sample remains. A wrong pointer or bank steering shows on the next offered pair, as a swapped or stale value on `left_smp` or `right_smp`. Each scenario therefore drains the FIFO until it is empty and checks every pair in order. This way a dropped write that was wrongly taken, or a lost sample, always shows up as a value mismatch.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  localparam int SMP_W = 20;

  typedef enum logic [1:0] {
    SZ16 = 2'd0,
    SZ18 = 2'd1,
    SZ20 = 2'd2,
    SZ12 = 2'd3
  } smp_size_e;

  // align a full-width bus word to the top of a 20-bit sample
  function automatic logic [SMP_W-1:0] align_word(input logic [31:0] w, input smp_size_e sz);
    logic [SMP_W-1:0] r;
    case (sz)
      SZ16:    r = {w[15:0], 4'b0};
      SZ18:    r = {w[17:0], 2'b0};
      SZ20:    r = w[19:0];
      default: r = {w[11:0], 8'b0};
    endcase
    return r;
  endfunction

  // align one 16-bit half in compact mode (only 16- and 12-bit widths)
  function automatic logic [SMP_W-1:0] align_half(input logic [15:0] h, input smp_size_e sz);
    logic [SMP_W-1:0] r;
    if (sz == SZ12) r = {h[11:0], 8'b0};
    else            r = {h, 4'b0};
    return r;
  endfunction

endpackage

// File: rtl/aud_tx_packer.sv
module aud_tx_packer
  import aud_tx_pkg::*;
(
  input  logic [31:0]      wr_data,
  input  logic [1:0]       size_sel,
  input  logic             compact_req,
  output logic [SMP_W-1:0] smp_first,
  output logic [SMP_W-1:0] smp_second,
  output logic             two_smp
);

  smp_size_e sz;

  always_comb begin
    sz      = smp_size_e'(size_sel);
    two_smp = compact_req && ((sz == SZ16) || (sz == SZ12));
    if (two_smp) begin
      smp_first  = align_half(wr_data[15:0], sz);
      smp_second = align_half(wr_data[31:16], sz);
    end else begin
      smp_first  = align_word(wr_data, sz);
      smp_second = '0;
    end
  end

endmodule

// File: rtl/aud_tx_banks.sv
module aud_tx_banks #(
  parameter int DEPTH = 8,
  parameter int SW    = 20,
  localparam int AW   = $clog2(DEPTH),
  localparam int RW   = AW - 1,
  localparam int ROWS = DEPTH / 2
) (
  input  logic          clk,
  input  logic          we_first,
  input  logic          we_second,
  input  logic [AW-1:0] wr_ptr,
  input  logic [SW-1:0] din_first,
  input  logic [SW-1:0] din_second,
  input  logic [RW-1:0] rd_row,
  output logic [SW-1:0] dout_even,
  output logic [SW-1:0] dout_odd
);

  logic [AW-1:0]        ptr_next;
  logic [1:0][SW-1:0]   rd_q;

  assign ptr_next = wr_ptr + AW'(1);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [SW-1:0] mem [ROWS];
    logic          hit_f, hit_s;
    logic [RW-1:0] row;
    logic [SW-1:0] wd;

    assign hit_f = we_first  && (wr_ptr[0]   == 1'(b));
    assign hit_s = we_second && (ptr_next[0] == 1'(b));
    assign row   = hit_f ? wr_ptr[AW-1:1] : ptr_next[AW-1:1];
    assign wd    = hit_f ? din_first : din_second;

    always_ff @(posedge clk) begin
      if (hit_f || hit_s) mem[row] <= wd;
    end

    assign rd_q[b] = mem[rd_row];
  end

  assign dout_even = rd_q[0];
  assign dout_odd  = rd_q[1];

endmodule

// File: rtl/aud_tx_status.sv
module aud_tx_status #(
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH) + 1,
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    push_cnt,
  input  logic          pop,
  output logic [LW-1:0] level,
  output logic          in_burst,
  output logic          flag_empty,
  output logic          flag_half,
  output logic          flag_full,
  output logic          flag_underrun
);

  logic [LW-1:0] lvl_mid, lvl_fin;
  logic          emp_n, half_n, full_n, und_n;

  always_comb begin
    lvl_mid = level + LW'(push_cnt);
    lvl_fin = pop ? (lvl_mid - LW'(2)) : lvl_mid;
    emp_n   = flag_empty;
    half_n  = flag_half;
    full_n  = flag_full;
    und_n   = flag_underrun;
    // push rules first
    if (push_cnt != 2'd0) begin
      if (lvl_mid != '0) begin
        emp_n = 1'b0;
        und_n = 1'b0;
      end
      if (lvl_mid >= LW'(HALF))  half_n = 1'b0;
      if (lvl_mid >= LW'(DEPTH)) full_n = 1'b1;
    end
    // then drain rules
    if (pop) begin
      full_n = 1'b0;
      if (lvl_fin <= LW'(HALF)) half_n = 1'b1;
      if (lvl_fin == '0) begin
        emp_n = 1'b1;
        und_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level         <= '0;
      in_burst      <= 1'b0;
      flag_empty    <= 1'b1;
      flag_half     <= 1'b1;
      flag_full     <= 1'b0;
      flag_underrun <= 1'b0;
    end else begin
      level         <= lvl_fin;
      in_burst      <= pop;
      flag_empty    <= emp_n;
      flag_half     <= half_n;
      flag_full     <= full_n;
      flag_underrun <= und_n;
    end
  end

  // R4
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));

  // R6
  full_level_chk: assert property (@(posedge clk) disable iff (rst)
    flag_full |-> (level == LW'(DEPTH)));

  // R9
  underrun_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flag_underrun |-> flag_empty);

  // R9
  drain_full_chk: assert property (@(posedge clk) disable iff (rst)
    pop |=> !flag_full);

endmodule

// File: rtl/aud_tx_fifo.sv
module aud_tx_fifo
  import aud_tx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1,
  localparam int HALF = DEPTH / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             chan_en,
  input  logic [1:0]       size_sel,
  input  logic             compact_req,
  input  logic [1:0]       slot_en,
  input  logic             pair_ready,
  output logic             pair_valid,
  output logic [SMP_W-1:0] left_smp,
  output logic [SMP_W-1:0] right_smp,
  output logic             flag_empty,
  output logic             flag_half,
  output logic             flag_full,
  output logic             flag_underrun
);

  logic [SMP_W-1:0] smp_first, smp_second;
  logic             two_smp;
  logic             accept;
  logic             fire;
  logic [1:0]       push_cnt;
  logic [LW-1:0]    level;
  logic             in_burst;
  logic [AW-1:0]    wr_ptr, rd_ptr;

  aud_tx_packer u_packer (
    .wr_data     (wr_data),
    .size_sel    (size_sel),
    .compact_req (compact_req),
    .smp_first   (smp_first),
    .smp_second  (smp_second),
    .two_smp     (two_smp)
  );

  // acceptance judged on the level before any drain in this cycle
  always_comb begin
    if (two_smp) accept = wr_en && ((level + LW'(2)) < LW'(DEPTH));
    else         accept = wr_en && (level < LW'(DEPTH));
    push_cnt = accept ? (two_smp ? 2'd2 : 2'd1) : 2'd0;
  end

  assign pair_valid = chan_en && (slot_en != 2'b00) && (level >= LW'(2)) &&
                      ((level >= LW'(HALF)) || in_burst);
  assign fire       = pair_valid && pair_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_cnt);
      if (fire) rd_ptr <= rd_ptr + AW'(2);
    end
  end

  aud_tx_banks #(.DEPTH(DEPTH), .SW(SMP_W)) u_banks (
    .clk        (clk),
    .we_first   (accept),
    .we_second  (accept && two_smp),
    .wr_ptr     (wr_ptr),
    .din_first  (smp_first),
    .din_second (smp_second),
    .rd_row     (rd_ptr[AW-1:1]),
    .dout_even  (left_smp),
    .dout_odd   (right_smp)
  );

  aud_tx_status #(.DEPTH(DEPTH)) u_status (
    .clk           (clk),
    .rst           (rst),
    .push_cnt      (push_cnt),
    .pop           (fire),
    .level         (level),
    .in_burst      (in_burst),
    .flag_empty    (flag_empty),
    .flag_half     (flag_half),
    .flag_full     (flag_full),
    .flag_underrun (flag_underrun)
  );

  // R7
  valid_level_chk: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> (level >= LW'(2)));

  // R8
  rd_even_chk: assert property (@(posedge clk) disable iff (rst)
    rd_ptr[0] == 1'b0);

  // R10
  level_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr - rd_ptr) == level[AW-1:0]);

  // R8
  burst_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && !pair_ready && (level < LW'(HALF))) |=> !pair_valid);

endmodule

// File: tb/test_aud_tx_fifo.sv
module test_aud_tx_fifo;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        chan_en = 1'b0;
  logic [1:0]  size_sel = 2'd0;
  logic        compact_req = 1'b0;
  logic [1:0]  slot_en = 2'b01;
  logic        pair_ready = 1'b0;
  logic        pair_valid;
  logic [19:0] left_smp, right_smp;
  logic        flag_empty, flag_half, flag_full, flag_underrun;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  aud_tx_fifo #(.DEPTH(8)) i_aud_tx_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .chan_en(chan_en),
    .size_sel(size_sel), .compact_req(compact_req), .slot_en(slot_en),
    .pair_ready(pair_ready), .pair_valid(pair_valid), .left_smp(left_smp),
    .right_smp(right_smp), .flag_empty(flag_empty), .flag_half(flag_half),
    .flag_full(flag_full), .flag_underrun(flag_underrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R1 expected normal-mode sample
  function automatic logic [19:0] exp_norm(input logic [31:0] w, input logic [1:0] sz);
    logic [31:0] t;
    case (sz)
      2'd0:    t = w << 4;
      2'd1:    t = w << 2;
      2'd2:    t = w;
      default: t = w << 8;
    endcase
    return t[19:0];
  endfunction

  // R2 expected compact-mode sample from a halfword
  function automatic logic [19:0] exp_half(input logic [15:0] h, input logic [1:0] sz);
    logic [31:0] t;
    t = (sz == 2'd3) ? ({16'b0, h} << 8) : ({16'b0, h} << 4);
    return t[19:0];
  endfunction

  // all tasks start and end just after a falling edge
  task automatic push(input logic [31:0] w, input logic [1:0] sz, input logic cmp);
    size_sel = sz; compact_req = cmp; wr_data = w; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic take_pair(input logic [19:0] el, input logic [19:0] er, input string req);
    #1;
    chk({req, " valid"}, 32'(pair_valid), 32'd1);
    chk({req, " left"},  32'(left_smp), 32'(el));
    chk({req, " right"}, 32'(right_smp), 32'(er));
    pair_ready = 1'b1;
    @(negedge clk);
    pair_ready = 1'b0;
  endtask

  task automatic flags(input logic [3:0] e, input string req);
    #1;
    chk({req, " flags e/h/f/u"}, 32'({flag_empty, flag_half, flag_full, flag_underrun}), 32'(e));
  endtask

  task automatic t_reset;
    // R5
    flags(4'b1100, "R5");
    chk("R5 valid", 32'(pair_valid), 32'd0);
  endtask

  task automatic t_pad_sizes;
    logic [31:0] w [4] = '{32'hABCDE123, 32'h0003_5A5B, 32'hFF0F_1234, 32'h1234_5ABC};
    chan_en = 1'b0; slot_en = 2'b01;
    push(w[0], 2'd0, 1'b0);
    flags(4'b0100, "R6 first push");
    push(w[1], 2'd1, 1'b0);
    push(w[2], 2'd2, 1'b0);
    flags(4'b0100, "R6 below half");
    push(w[3], 2'd3, 1'b0);
    flags(4'b0000, "R6 at half");
    #1; chk("R7 disabled channel", 32'(pair_valid), 32'd0);
    chan_en = 1'b1;
    take_pair(exp_norm(w[0], 2'd0), exp_norm(w[1], 2'd1), "R1 R7 pair0");
    flags(4'b0100, "R9 half after drain");
    take_pair(exp_norm(w[2], 2'd2), exp_norm(w[3], 2'd3), "R1 R8 burst pair1");
    flags(4'b1101, "R9 empty after drain");
    #1; chk("R7 idle when empty", 32'(pair_valid), 32'd0);
  endtask

  task automatic t_full_burst;
    logic [31:0] a = 32'h000A_AAAA;
    logic [31:0] b = 32'h000B_BBBB;
    chan_en = 1'b0;
    for (int i = 0; i < 8; i++) begin
      push(32'h0001_0000 * (i + 1) + 32'(i), 2'd2, 1'b1);  // R3 compact ignored
      if (i == 0) flags(4'b0100, "R6 push clears underrun");
    end
    flags(4'b0010, "R6 full");
    push(32'h000F_FFFF, 2'd2, 1'b0);  // R4 dropped at full
    flags(4'b0010, "R4 full unchanged");
    chan_en = 1'b1;
    take_pair(20'h10000, 20'h20001, "R3 pair0");
    flags(4'b0000, "R9 full cleared");
    take_pair(20'h30002, 20'h40003, "R3 pair1");
    flags(4'b0100, "R9 half at half");
    take_pair(20'h50004, 20'h60005, "R8 pair2");
    #1; chk("R8 burst holds below half", 32'(pair_valid), 32'd1);
    @(negedge clk);
    #1; chk("R8 burst ended", 32'(pair_valid), 32'd0);
    push(a, 2'd2, 1'b0);
    #1; chk("R7 below half", 32'(pair_valid), 32'd0);
    push(b, 2'd2, 1'b0);
    take_pair(20'h70006, 20'h80007, "R4 pair3");
    take_pair(20'hAAAAA, 20'hBBBBB, "R4 R8 pair4");
    flags(4'b1101, "R4 empty");
  endtask

  task automatic t_compact;
    chan_en = 1'b0;
    push(32'h1234_5678, 2'd0, 1'b1);
    push(32'h00AB_00CD, 2'd3, 1'b1);
    flags(4'b0000, "R6 compact half");
    push(32'h0F0F_0E0E, 2'd0, 1'b1);
    push(32'h1111_2222, 2'd0, 1'b1);  // R4 level+2 not below depth: dropped
    push(32'h000A_BCDE, 2'd2, 1'b0);  // R4 normal write still fits
    flags(4'b0000, "R4 not full");
    chan_en = 1'b1;
    take_pair(exp_half(16'h5678, 2'd0), exp_half(16'h1234, 2'd0), "R2 pair0");
    take_pair(exp_half(16'h00CD, 2'd3), exp_half(16'h00AB, 2'd3), "R2 pair1");
    take_pair(exp_half(16'h0E0E, 2'd0), exp_half(16'h0F0F, 2'd0), "R2 pair2");
    #1; chk("R8 single left", 32'(pair_valid), 32'd0);
    push(32'h0001_1111, 2'd2, 1'b0);
    push(32'h0002_2222, 2'd2, 1'b0);
    push(32'h0003_3333, 2'd2, 1'b0);
    take_pair(20'hABCDE, 20'h11111, "R4 compact drop pair3");
    take_pair(20'h22222, 20'h33333, "R4 pair4");
    flags(4'b1101, "R2 empty");
  endtask

  task automatic t_slots_simul;
    chan_en = 1'b1; slot_en = 2'b00;
    for (int i = 0; i < 4; i++) push(32'h0000_0100 + 32'(i), 2'd2, 1'b0);
    #1; chk("R7 no slot", 32'(pair_valid), 32'd0);
    slot_en = 2'b10;
    #1; chk("R7 slot4 valid", 32'(pair_valid), 32'd1);
    chk("R7 slot4 left", 32'(left_smp), 32'h100);
    // R10 write and drain in the same cycle
    size_sel = 2'd2; compact_req = 1'b0; wr_data = 32'h0000_0104;
    wr_en = 1'b1; pair_ready = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; pair_ready = 1'b0;
    flags(4'b0100, "R10 flags net");
    take_pair(20'h00102, 20'h00103, "R10 burst after overlap");
    #1; chk("R10 one left", 32'(pair_valid), 32'd0);
    push(32'h0000_0105, 2'd2, 1'b0);
    push(32'h0000_0106, 2'd2, 1'b0);
    #1; chk("R10 three held", 32'(pair_valid), 32'd0);
    push(32'h0000_0107, 2'd2, 1'b0);
    take_pair(20'h00104, 20'h00105, "R10 pair");
    take_pair(20'h00106, 20'h00107, "R10 last pair");
    flags(4'b1101, "R10 empty");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pad_sizes();
    t_full_burst();
    t_compact();
    t_slots_simul();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule